// File: doc/BRIEF.md
# Level/Edge Interrupt Redirection Controller

This block routes a bank of device interrupt lines to processors. Each line owns a redirection entry that holds a vector, a destination, a mask, a trigger-mode select and a remote-IRR status bit. Software programs the entries through a two-register indirect window: it writes an index into a select register and then reads or writes the data register. The block samples the input lines every clock. It decides when an interrupt message is due and presents that message (vector plus destination) on a valid/ready delivery port. End-of-interrupt broadcasts come back carrying a vector, and they release level-triggered entries that are waiting for service to finish.

Edge-triggered lines produce one message per rising edge. A pulse that arrives while the entry is masked is dropped. Level-triggered lines produce a message whenever the line is high, the entry is unmasked and the entry is not already in service. This gives exact behaviour when software unmasks a line that is still high, when the line is still high after an EOI, and when the line toggles several times while its handler runs.

Top module: `ioredir_ctrl`

## Requirements
- R1: After reset every entry reads back masked, edge-triggered, with vector 0, destination 0 and remote-IRR clear. Its low word is 0x0001_0000. No message is valid.
- R2: Offset 0x00 holds an 8-bit select value and reads it back in bits [7:0]. Offset 0x10 is the data window. Select 0x10+2n reaches the low word of entry n: vector in [7:0], remote-IRR in bit 14 (read-only), trigger in bit 15 (1 = level, 0 = edge), mask in bit 16 (1 = masked). Select 0x11+2n reaches the high word: destination in [31:24]. Selects outside 0x10..0x3F read 0 through the window and ignore writes. Any other offset reads 0 and ignores writes.
- R3: A level-triggered line that is high while its entry is masked produces no message. Once the mask is cleared, a message follows if the line is still high.
- R4: Accepting a level-triggered message sets that entry's remote-IRR bit. While the bit is set, the entry produces no further message, even if the line stays high.
- R5: An EOI whose vector equals a level-triggered entry's vector clears that entry's remote-IRR. If the line is still high, the entry is delivered again. An EOI with a different vector has no effect.
- R6: If a level line falls, rises and falls again while its entry is in service, there is exactly one message in total.
- R7: A rising edge on an unmasked edge-triggered line is held pending until its message is accepted. A rising edge while masked is discarded and is not delivered when the entry is later unmasked.
- R8: Only one message is presented at a time. Among pending entries the lowest-numbered one wins. Vector and destination stay unchanged until valid and ready are high together.
- R9: A message becomes valid on the clock edge after its request arises. Each message is accepted on the edge where valid and ready are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | N_LINES | Interrupt input lines, one per entry |
| bus_addr | input | 8 | Register offset (0x00 select, 0x10 window) |
| bus_wr | input | 1 | Register write strobe |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for bus_addr |
| eoi_valid | input | 1 | EOI broadcast strobe |
| eoi_vector | input | VEC_W | Vector carried by the EOI |
| msg_valid | output | 1 | Interrupt message present |
| msg_ready | input | 1 | Receiver takes the message |
| msg_vector | output | VEC_W | Vector of the presented message |
| msg_dest | output | DEST_W | Destination of the presented message |

## Verification
The bench targets the three level-triggered traps. In the first, the line is raised under the mask and the entry is then unmasked; a design that only reacts to edges of the line never delivers. In the second, the line is still high after a matching EOI; a design that forgets to re-evaluate stays silent and the system hangs. In the third, the line toggles while in service; a design that latches the toggles delivers twice. It also checks that a masked edge pulse is discarded, that the lowest index wins with the message held stable under backpressure, and that a non-matching EOI leaves remote-IRR set. A random phase then mixes both trigger modes, backpressure and EOIs against a reference model.

// File: rtl/ioredir_pkg.sv
package ioredir_pkg;
  localparam logic [7:0] REG_SELECT = 8'h00;
  localparam logic [7:0] REG_WINDOW = 8'h10;
  localparam int ENTRY_BASE = 16;
  localparam int BIT_RIRR   = 14;
  localparam int BIT_LEVEL  = 15;
  localparam int BIT_MASK   = 16;
  localparam int DEST_LSB   = 24;

  // True when the select value addresses a word of one of n_entries entries
  function automatic logic sel_in_table(input logic [7:0] sel, input int n_entries);
    return (int'(sel) >= ENTRY_BASE) && (int'(sel) < ENTRY_BASE + 2 * n_entries);
  endfunction

  // Entry number addressed by a select value (valid only when sel_in_table)
  function automatic int sel_entry(input logic [7:0] sel);
    return (int'(sel) - ENTRY_BASE) / 2;
  endfunction
endpackage

// File: rtl/ioredir_regs.sv
module ioredir_regs
  import ioredir_pkg::*;
#(
  parameter int N_LINES = 24,
  parameter int VEC_W   = 8,
  parameter int DEST_W  = 8
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [7:0]                       bus_addr,
  input  logic                             bus_wr,
  input  logic [31:0]                      bus_wdata,
  output logic [31:0]                      bus_rdata,
  input  logic [N_LINES-1:0]               ent_rirr,
  output logic [N_LINES-1:0]               ent_mask,
  output logic [N_LINES-1:0]               ent_level,
  output logic [N_LINES-1:0][VEC_W-1:0]    ent_vec,
  output logic [N_LINES-1:0][DEST_W-1:0]   ent_dest
);
  localparam int IW = (N_LINES > 1) ? $clog2(N_LINES) : 1;

  logic [7:0]    sel;
  logic          hit;
  logic          hi_word;
  logic [IW-1:0] eidx;

  always_comb begin
    hit     = sel_in_table(sel, N_LINES);
    hi_word = sel[0];
    eidx    = IW'(sel_entry(sel));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel       <= '0;
      ent_mask  <= '1;
      ent_level <= '0;
      ent_vec   <= '0;
      ent_dest  <= '0;
    end else if (bus_wr) begin
      if (bus_addr == REG_SELECT) begin
        sel <= bus_wdata[7:0];
      end else if (bus_addr == REG_WINDOW && hit) begin
        if (hi_word) begin
          ent_dest[eidx] <= bus_wdata[DEST_LSB +: DEST_W];
        end else begin
          ent_vec[eidx]   <= bus_wdata[VEC_W-1:0];
          ent_level[eidx] <= bus_wdata[BIT_LEVEL];
          ent_mask[eidx]  <= bus_wdata[BIT_MASK];
        end
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == REG_SELECT) begin
      bus_rdata[7:0] = sel;
    end else if (bus_addr == REG_WINDOW && hit) begin
      if (hi_word) begin
        bus_rdata[DEST_LSB +: DEST_W] = ent_dest[eidx];
      end else begin
        bus_rdata[VEC_W-1:0] = ent_vec[eidx];
        bus_rdata[BIT_RIRR]  = ent_rirr[eidx];
        bus_rdata[BIT_LEVEL] = ent_level[eidx];
        bus_rdata[BIT_MASK]  = ent_mask[eidx];
      end
    end
  end

  AST_SELECT_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && bus_addr == REG_SELECT |=> sel == $past(bus_wdata[7:0])); // R2
endmodule

// File: rtl/ioredir_line.sv
module ioredir_line #(
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line,
  input  logic             mask,
  input  logic             level,
  input  logic [VEC_W-1:0] vec,
  input  logic             eoi_valid,
  input  logic [VEC_W-1:0] eoi_vector,
  input  logic             accept,
  output logic             req,
  output logic             rirr
);
  logic prev;
  logic edge_pend;
  logic rise;
  logic eoi_hit;

  assign rise    = line && !prev;
  assign eoi_hit = eoi_valid && (eoi_vector == vec) && level;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev      <= 1'b0;
      edge_pend <= 1'b0;
      rirr      <= 1'b0;
    end else begin
      prev <= line;
      if (level)                edge_pend <= 1'b0;
      else if (rise && !mask)   edge_pend <= 1'b1;
      else if (accept)          edge_pend <= 1'b0;
      if (accept && level)      rirr <= 1'b1;
      else if (eoi_hit)         rirr <= 1'b0;
    end
  end

  assign req = !mask && (level ? (line && !rirr) : edge_pend);

  AST_LEVEL_ACCEPT_SETS_RIRR: assert property (@(posedge clk) disable iff (!rst_n)
    accept && level |=> rirr); // R4
  AST_EOI_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_hit && !accept |=> !rirr); // R5
  AST_EDGE_CONSUMED: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !level && !rise |=> level || !req); // R7
endmodule

// File: rtl/ioredir_pick.sv
module ioredir_pick #(
  parameter int N_LINES = 24,
  parameter int VEC_W   = 8,
  parameter int DEST_W  = 8
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [N_LINES-1:0]             req,
  input  logic [N_LINES-1:0][VEC_W-1:0]  ent_vec,
  input  logic [N_LINES-1:0][DEST_W-1:0] ent_dest,
  input  logic                           msg_ready,
  output logic                           msg_valid,
  output logic [VEC_W-1:0]               msg_vector,
  output logic [DEST_W-1:0]              msg_dest,
  output logic [N_LINES-1:0]             accept
);
  localparam int IW = (N_LINES > 1) ? $clog2(N_LINES) : 1;

  logic          any_req;
  logic [IW-1:0] first;
  logic [IW-1:0] held_idx;

  always_comb begin
    any_req = 1'b0;
    first   = '0;
    for (int i = N_LINES - 1; i >= 0; i--) begin
      if (req[i]) begin
        any_req = 1'b1;
        first   = IW'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      msg_valid  <= 1'b0;
      held_idx   <= '0;
      msg_vector <= '0;
      msg_dest   <= '0;
    end else if (msg_valid && msg_ready) begin
      msg_valid <= 1'b0;
    end else if (!msg_valid && any_req) begin
      msg_valid  <= 1'b1;
      held_idx   <= first;
      msg_vector <= ent_vec[first];
      msg_dest   <= ent_dest[first];
    end
  end

  for (genvar g = 0; g < N_LINES; g++) begin : g_acc
    assign accept[g] = msg_valid && msg_ready && (held_idx == IW'(g));
  end

  AST_HOLD_UNDER_BACKPRESSURE: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && !msg_ready |=> msg_valid && $stable(msg_vector) && $stable(msg_dest)); // R8
  AST_HANDSHAKE_RETIRES: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && msg_ready |=> !msg_valid); // R9
endmodule

// File: rtl/ioredir_ctrl.sv
module ioredir_ctrl #(
  parameter int N_LINES = 24,
  parameter int VEC_W   = 8,
  parameter int DEST_W  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] irq_in,
  input  logic [7:0]         bus_addr,
  input  logic               bus_wr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  input  logic               eoi_valid,
  input  logic [VEC_W-1:0]   eoi_vector,
  output logic               msg_valid,
  input  logic               msg_ready,
  output logic [VEC_W-1:0]   msg_vector,
  output logic [DEST_W-1:0]  msg_dest
);
  logic [N_LINES-1:0]             ent_mask;
  logic [N_LINES-1:0]             ent_level;
  logic [N_LINES-1:0]             ent_rirr;
  logic [N_LINES-1:0][VEC_W-1:0]  ent_vec;
  logic [N_LINES-1:0][DEST_W-1:0] ent_dest;
  logic [N_LINES-1:0]             req;
  logic [N_LINES-1:0]             accept;

  ioredir_regs #(.N_LINES(N_LINES), .VEC_W(VEC_W), .DEST_W(DEST_W)) regs_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ent_rirr(ent_rirr),
    .ent_mask(ent_mask), .ent_level(ent_level), .ent_vec(ent_vec), .ent_dest(ent_dest)
  );

  for (genvar g = 0; g < N_LINES; g++) begin : g_line
    ioredir_line #(.VEC_W(VEC_W)) line_i (
      .clk(clk), .rst_n(rst_n), .line(irq_in[g]), .mask(ent_mask[g]),
      .level(ent_level[g]), .vec(ent_vec[g]), .eoi_valid(eoi_valid),
      .eoi_vector(eoi_vector), .accept(accept[g]), .req(req[g]), .rirr(ent_rirr[g])
    );
  end

  ioredir_pick #(.N_LINES(N_LINES), .VEC_W(VEC_W), .DEST_W(DEST_W)) pick_i (
    .clk(clk), .rst_n(rst_n), .req(req), .ent_vec(ent_vec), .ent_dest(ent_dest),
    .msg_ready(msg_ready), .msg_valid(msg_valid), .msg_vector(msg_vector),
    .msg_dest(msg_dest), .accept(accept)
  );

  AST_RESET_IDLE: assert property (@(posedge clk)
    !rst_n |=> !msg_valid); // R1
endmodule

// File: tb/ioredir_ctrl_tb_top.sv
module ioredir_ctrl_tb_top;
  localparam int N = 24;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] irq_in = '0;
  logic [7:0]   bus_addr = '0;
  logic         bus_wr = 1'b0;
  logic [31:0]  bus_wdata = '0;
  logic [31:0]  bus_rdata;
  logic         eoi_valid = 1'b0;
  logic [7:0]   eoi_vector = '0;
  logic         msg_valid;
  logic         msg_ready = 1'b1;
  logic [7:0]   msg_vector;
  logic [7:0]   msg_dest;

  always #10 clk = ~clk;

  ioredir_ctrl #(.N_LINES(N), .VEC_W(8), .DEST_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .eoi_valid(eoi_valid),
    .eoi_vector(eoi_vector), .msg_valid(msg_valid), .msg_ready(msg_ready),
    .msg_vector(msg_vector), .msg_dest(msg_dest)
  );

  int    n_vec = 0;
  int    n_bad = 0;
  string phase = "R1";
  int    acc_q[$];

  // Behavioural reference model
  bit m_mask[N], m_lvl[N], m_rirr[N], m_ep[N], m_prev[N];
  int m_vec[N], m_dest[N];
  int m_sel;
  bit m_ov;
  int m_ovec, m_odest;
  int m_oi;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin
        m_mask[i] = 1; m_lvl[i] = 0; m_rirr[i] = 0; m_ep[i] = 0; m_prev[i] = 0;
        m_vec[i] = 0; m_dest[i] = 0;
      end
      m_sel = 0; m_ov = 0; m_ovec = 0; m_odest = 0; m_oi = 0;
    end else begin
      bit r[N];
      int first;
      first = -1;
      if (msg_valid && msg_ready) acc_q.push_back(int'(msg_vector));
      for (int i = 0; i < N; i++) begin
        r[i] = !m_mask[i] && (m_lvl[i] ? (irq_in[i] && !m_rirr[i]) : m_ep[i]);
        if (r[i] && first < 0) first = i;
      end
      for (int i = 0; i < N; i++) begin
        bit acc;
        acc = m_ov && msg_ready && (m_oi == i);
        if (m_lvl[i]) m_ep[i] = 0;
        else if (irq_in[i] && !m_prev[i] && !m_mask[i]) m_ep[i] = 1;
        else if (acc) m_ep[i] = 0;
        if (acc && m_lvl[i]) m_rirr[i] = 1;
        else if (eoi_valid && int'(eoi_vector) == m_vec[i] && m_lvl[i]) m_rirr[i] = 0;
        m_prev[i] = irq_in[i];
      end
      if (m_ov && msg_ready) m_ov = 0;
      else if (!m_ov && first >= 0) begin
        m_ov = 1; m_oi = first; m_ovec = m_vec[first]; m_odest = m_dest[first];
      end
      if (bus_wr) begin
        if (bus_addr == 8'h00) m_sel = int'(bus_wdata[7:0]);
        else if (bus_addr == 8'h10 && m_sel >= 16 && m_sel < 16 + 2 * N) begin
          int e;
          e = (m_sel - 16) / 2;
          if (m_sel % 2 == 1) m_dest[e] = int'(bus_wdata[31:24]);
          else begin
            m_vec[e] = int'(bus_wdata[7:0]); m_lvl[e] = bus_wdata[15]; m_mask[e] = bus_wdata[16];
          end
        end
      end
    end
  end

  function automatic logic [31:0] exp_rdata(input logic [7:0] a);
    logic [31:0] v;
    v = 0;
    if (a == 8'h00) v = 32'(m_sel);
    else if (a == 8'h10 && m_sel >= 16 && m_sel < 16 + 2 * N) begin
      int e;
      e = (m_sel - 16) / 2;
      if (m_sel % 2 == 1) v = 32'(m_dest[e]) << 24;
      else v = (32'(m_mask[e]) << 16) | (32'(m_lvl[e]) << 15) | (32'(m_rirr[e]) << 14) | 32'(m_vec[e]);
    end
    return v;
  endfunction

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", rq, act, exp);
    end
  endtask

  // One clock; compare against the model at the falling edge
  task automatic tick();
    @(negedge clk);
    if (rst_n) begin
      chk(msg_valid == m_ov, {phase, " msg_valid"}, int'(msg_valid), int'(m_ov));
      if (m_ov) begin
        chk(int'(msg_vector) == m_ovec, {phase, " msg_vector"}, int'(msg_vector), m_ovec);
        chk(int'(msg_dest) == m_odest, {phase, " msg_dest"}, int'(msg_dest), m_odest);
      end
      chk(bus_rdata == exp_rdata(bus_addr), {phase, " bus_rdata"}, int'(bus_rdata), int'(exp_rdata(bus_addr)));
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    tick();
    bus_wr = 1'b0;
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string rq);
    bus_addr = a;
    tick();
    chk(bus_rdata == exp, rq, int'(bus_rdata), int'(exp));
  endtask

  task automatic prog(input int e, input logic [31:0] low);
    wr(8'h00, 32'(16 + 2 * e));
    wr(8'h10, low);
  endtask

  task automatic eoi(input logic [7:0] v);
    eoi_valid = 1'b1; eoi_vector = v;
    tick();
    eoi_valid = 1'b0;
  endtask

  task automatic pulse(input int i);
    irq_in[i] = 1'b1;
    tick();
    irq_in[i] = 1'b0;
  endtask

  bit done = 0;
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    phase = "R1";
    chk(msg_valid == 1'b0, "R1 idle after reset", int'(msg_valid), 0);
    for (int e = 0; e < N; e++) begin
      wr(8'h00, 32'(16 + 2 * e));
      rd_chk(8'h10, 32'h0001_0000, "R1 entry low word");
    end
    // R2: register window
    phase = "R2";
    wr(8'h00, 32'h17);
    wr(8'h10, 32'hA5FF_FFFF);
    rd_chk(8'h10, 32'hA500_0000, "R2 high word dest");
    prog(3, 32'h0001_8033);
    rd_chk(8'h10, 32'h0001_8033, "R2 low word fields");
    rd_chk(8'h00, 32'h16, "R2 select readback");
    wr(8'h00, 32'h40);
    wr(8'h10, 32'hFFFF_FFFF);
    rd_chk(8'h10, 32'h0, "R2 unmapped select");
    wr(8'h08, 32'hFFFF_FFFF);
    rd_chk(8'h08, 32'h0, "R2 other offset");
    // R3: level line raised under mask, then unmasked
    phase = "R3";
    acc_q.delete();
    wr(8'h00, 32'h16);
    irq_in[3] = 1'b1;
    ticks(5);
    chk(acc_q.size() == 0, "R3 masked level silent", acc_q.size(), 0);
    wr(8'h10, 32'h0000_8033);
    ticks(4);
    chk(acc_q.size() == 1, "R3 delivered on unmask", acc_q.size(), 1);
    if (acc_q.size() > 0) chk(acc_q[0] == 32'h33, "R3 vector", acc_q[0], 32'h33);
    // R4: in service blocks redelivery
    phase = "R4";
    ticks(10);
    chk(acc_q.size() == 1, "R4 no redelivery in service", acc_q.size(), 1);
    rd_chk(8'h10, 32'h0000_C033, "R4 remote-IRR set");
    // R5: EOI behaviour
    phase = "R5";
    eoi(8'h34);
    ticks(5);
    chk(acc_q.size() == 1, "R5 other vector ignored", acc_q.size(), 1);
    rd_chk(8'h10, 32'h0000_C033, "R5 remote-IRR kept");
    eoi(8'h33);
    ticks(4);
    chk(acc_q.size() == 2, "R5 redelivered after EOI", acc_q.size(), 2);
    irq_in[3] = 1'b0;
    eoi(8'h33);
    ticks(3);
    chk(acc_q.size() == 2, "R5 no delivery with line low", acc_q.size(), 2);
    rd_chk(8'h10, 32'h0000_8033, "R5 remote-IRR cleared");
    // R9 and R6: latency, then coalescing while in service
    phase = "R6";
    acc_q.delete();
    irq_in[3] = 1'b1;
    tick();
    chk(msg_valid == 1'b1, "R9 valid one edge after request", int'(msg_valid), 1);
    ticks(2);
    irq_in[3] = 1'b0; tick();
    irq_in[3] = 1'b1; tick();
    irq_in[3] = 1'b0; tick();
    eoi(8'h33);
    ticks(5);
    chk(acc_q.size() == 1, "R6 toggles coalesced", acc_q.size(), 1);
    // R7: edge entries
    phase = "R7";
    prog(5, 32'h0000_0055);
    prog(6, 32'h0001_0066);
    acc_q.delete();
    pulse(5);
    ticks(4);
    chk(acc_q.size() == 1, "R7 one message per pulse", acc_q.size(), 1);
    pulse(6);
    ticks(3);
    prog(6, 32'h0000_0066);
    ticks(4);
    chk(acc_q.size() == 1, "R7 masked pulse discarded", acc_q.size(), 1);
    msg_ready = 1'b0;
    pulse(5);
    ticks(3);
    chk(msg_valid && msg_vector == 8'h55, "R7 pulse held pending", int'(msg_vector), 32'h55);
    msg_ready = 1'b1;
    ticks(2);
    chk(acc_q.size() == 2, "R7 pending pulse delivered", acc_q.size(), 2);
    // R8: ordering and hold
    phase = "R8";
    prog(2, 32'h0000_0022);
    prog(7, 32'h0000_0077);
    acc_q.delete();
    msg_ready = 1'b0;
    irq_in[2] = 1'b1; irq_in[7] = 1'b1;
    tick();
    irq_in[2] = 1'b0; irq_in[7] = 1'b0;
    ticks(3);
    chk(msg_vector == 8'h22, "R8 lowest index first", int'(msg_vector), 32'h22);
    ticks(3);
    chk(msg_valid && msg_vector == 8'h22, "R8 held under backpressure", int'(msg_vector), 32'h22);
    msg_ready = 1'b1;
    ticks(6);
    chk(acc_q.size() == 2, "R8 both delivered", acc_q.size(), 2);
    if (acc_q.size() == 2) chk(acc_q[1] == 32'h77, "R8 order", acc_q[1], 32'h77);
    // Random mix against the model (R3 R4 R5 R7 R8 R9)
    phase = "R9 random";
    for (int e = 0; e < 8; e++) begin
      wr(8'h00, 32'(17 + 2 * e));
      wr(8'h10, 32'(e) << 24);
      prog(e, (e % 2 == 0 ? 32'h0000_8000 : 32'h0) | 32'(8'h40 + e));
    end
    for (int c = 0; c < 2000; c++) begin
      for (int i = 0; i < 8; i++) begin
        if (i % 2 == 0) begin
          if ($urandom % 8 == 0) irq_in[i] = ~irq_in[i];
        end else irq_in[i] = !irq_in[i] && ($urandom % 10 == 0);
      end
      msg_ready = ($urandom % 3 != 0);
      eoi_valid = ($urandom % 4 == 0);
      eoi_vector = 8'h40 + 8'($urandom % 8);
      tick();
    end
    eoi_valid = 1'b0;
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule